// File: doc/BRIEF.md
# Character Dot Serializer with Stretching

This block turns one scan-line slice of a character's dot pattern into a serial video dot stream. The character generator presents a parallel dot word. An active-low load strobe captures that word. On every dot clock after the load, one dot leaves the register, least significant bit first. A zero enters the vacated top end, so a register that has not been reloaded runs out into dark dots.

Each serial dot passes through a two-stage latch. The output is the current dot ORed with the dot before it. This widens every lit run by one trailing dot period, whether the run is a single dot or several. Three inputs act on the output:
- An underline attribute lights the whole cell on the underline scan line.
- A blanking input clears the latch and forces the output dark.
- An inhibit input freezes the register, the latch and the output, so that the stream resumes where it stopped.

Top module: `dot_serializer`

## Requirements
- R1: On a clock edge where `load_n` is 0, the shift register takes `dots`. This happens whatever the value of `inhibit`.
- R2: On an edge where `load_n` is 1 and `inhibit` is 0, the register moves one place toward bit 0, and a 0 enters the top bit.
- R3: Bit 0 of the loaded word is the first dot of the cell. Take the load edge as edge 0 and name the dots D[0..7]. Without stretching, dot D[k] reaches `video` after edge k+2.
- R4: Stretching: after edge k+2, `video` = D[k] OR D[k-1], with D[-1] = 0 after reset and D[8] = 0. A lit run therefore ends one dot later than in the pattern.
- R5: When `inhibit` is 1 and `load_n` is 1, the register, the latch and `video` all hold their values. When `inhibit` returns to 0, the stream continues with the next dot, and no dot is lost.
- R6: When `underline` is 1 and `scan_line` equals 8 (the ninth line, counted from zero), `video` is 1 after the edge. On any other `scan_line` value, the underline input has no effect.
- R7: When `blank` is 1, `video` is 0 after the edge, and both latch stages are cleared. The dot after the edge that follows the blank is therefore dark as well.
- R8: `blank` takes priority over the underline force, and the underline force takes priority over the stretched dot.
- R9: A synchronous `rst` clears the register, the latch and `video`. After reset the output stays 0 until a new word is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low character load strobe |
| inhibit | input | 1 | Shift inhibit; freezes the stream while high |
| dots | input | DOT_W | Parallel dot word for the current scan line |
| underline | input | 1 | Underline attribute of the character |
| scan_line | input | LINE_W | Current scan line within the character row |
| blank | input | 1 | Blanking input; clears the latch and darkens the output |
| video | output | 1 | Serial video dot, registered |

## Verification
Every one of the 256 dot words is streamed out, and the output is compared with the OR of each bit and its predecessor. This tells apart bit order, lit runs, isolated dots and the stretch past the last bit. The same sweep is repeated with an inhibit pause placed at a different dot for each word. This separates a true freeze from a lost or doubled dot. The underline condition is swept over all 16 scan-line values, together with several patterns, to show that only line 8 forces the cell lit. Blanking is applied in the middle of a stream, with underline also active, to show that blank wins and that the cleared latch darkens the following dot.

// File: rtl/dser_pkg.sv
package dser_pkg;
  localparam int unsigned DEF_DOT_W   = 8;
  localparam int unsigned DEF_LINE_W  = 4;
  localparam int unsigned DEF_UL_LINE = 8;

  typedef enum logic [1:0] {
    SEL_DARK = 2'd0,
    SEL_LIT  = 2'd1,
    SEL_DOT  = 2'd2,
    SEL_HOLD = 2'd3
  } vsel_e;
endpackage

// File: rtl/dser_shifter.sv
module dser_shifter #(
  parameter int unsigned DOT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_n,
  input  logic             inhibit,
  input  logic [DOT_W-1:0] dots,
  output logic             ser_out
);
  logic [DOT_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst)          sr_q <= '0;
    else if (!load_n) sr_q <= dots;
    else if (!inhibit) sr_q <= {1'b0, sr_q[DOT_W-1:1]};
  end

  assign ser_out = sr_q[0];

  AST_LOAD_TAKES_WORD: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> sr_q == $past(dots)); // R1
  AST_SHIFT_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
    (load_n && !inhibit) |=> sr_q == {1'b0, $past(sr_q[DOT_W-1:1])}); // R2
  AST_SHIFT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (load_n && inhibit) |=> $stable(sr_q)); // R5
endmodule

// File: rtl/dser_stretch.sv
module dser_stretch (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  input  logic ser_in,
  output logic cur_q,
  output logic prev_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
    end else if (adv) begin
      cur_q  <= ser_in;
      prev_q <= cur_q;
    end
  end

  AST_BLANK_CLEARS_LATCH: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!cur_q && !prev_q)); // R7
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!clr && !adv) |=> ($stable(cur_q) && $stable(prev_q))); // R5
endmodule

// File: rtl/dser_line_match.sv
module dser_line_match #(
  parameter int unsigned LINE_W  = 4,
  parameter int unsigned UL_LINE = 8
) (
  input  logic              underline,
  input  logic [LINE_W-1:0] scan_line,
  output logic              ul_hit
);
  localparam logic [LINE_W-1:0] UL_CODE = LINE_W'(UL_LINE);

  assign ul_hit = underline && (scan_line == UL_CODE);
endmodule

// File: rtl/dser_video_out.sv
module dser_video_out
  import dser_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic blank,
  input  logic ul_hit,
  input  logic adv,
  input  logic cur_dot,
  input  logic prev_dot,
  output logic video
);
  vsel_e sel;

  always_comb begin
    if (blank)       sel = SEL_DARK;
    else if (ul_hit) sel = SEL_LIT;
    else if (adv)    sel = SEL_DOT;
    else             sel = SEL_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) video <= 1'b0;
    else begin
      case (sel)
        SEL_DARK: video <= 1'b0;
        SEL_LIT:  video <= 1'b1;
        SEL_DOT:  video <= cur_dot | prev_dot;
        default:  video <= video;
      endcase
    end
  end

  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (rst)
    blank |=> !video); // R8
  AST_UNDERLINE_LIT: assert property (@(posedge clk) disable iff (rst)
    (!blank && ul_hit) |=> video); // R6
  AST_STRETCH_TAIL: assert property (@(posedge clk) disable iff (rst)
    (!blank && !ul_hit && adv && prev_dot) |=> video); // R4
endmodule

// File: rtl/dot_serializer.sv
module dot_serializer
  import dser_pkg::*;
#(
  parameter int unsigned DOT_W   = DEF_DOT_W,
  parameter int unsigned LINE_W  = DEF_LINE_W,
  parameter int unsigned UL_LINE = DEF_UL_LINE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_n,
  input  logic              inhibit,
  input  logic [DOT_W-1:0]  dots,
  input  logic              underline,
  input  logic [LINE_W-1:0] scan_line,
  input  logic              blank,
  output logic              video
);
  logic ser_bit;
  logic cur_dot;
  logic prev_dot;
  logic ul_hit;
  logic adv;

  assign adv = !inhibit;

  dser_shifter #(.DOT_W(DOT_W)) u_shift (
    .clk(clk), .rst(rst), .load_n(load_n), .inhibit(inhibit),
    .dots(dots), .ser_out(ser_bit)
  );

  dser_stretch u_latch (
    .clk(clk), .rst(rst), .clr(blank), .adv(adv),
    .ser_in(ser_bit), .cur_q(cur_dot), .prev_q(prev_dot)
  );

  dser_line_match #(.LINE_W(LINE_W), .UL_LINE(UL_LINE)) u_match (
    .underline(underline), .scan_line(scan_line), .ul_hit(ul_hit)
  );

  dser_video_out u_out (
    .clk(clk), .rst(rst), .blank(blank), .ul_hit(ul_hit), .adv(adv),
    .cur_dot(cur_dot), .prev_dot(prev_dot), .video(video)
  );

  AST_RESET_DARK: assert property (@(posedge clk)
    rst |=> !video); // R9
endmodule

// File: tb/test_dot_serializer.sv
module test_dot_serializer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_n = 1'b1;
  logic       inhibit = 1'b0;
  logic [7:0] dots = '0;
  logic       underline = 1'b0;
  logic [3:0] scan_line = '0;
  logic       blank = 1'b0;
  logic       video;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dot_serializer i_dot_serializer (
    .clk(clk), .rst(rst), .load_n(load_n), .inhibit(inhibit), .dots(dots),
    .underline(underline), .scan_line(scan_line), .blank(blank), .video(video)
  );

  function automatic logic bitof(input logic [7:0] d, input int k);
    if (k < 0 || k > 7) return 1'b0;
    return d[k];
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input logic exp, input string req);
    n_vec++;
    if (video !== exp) begin
      n_bad++;
      $display("FAIL %s: video=%b expected=%b (dots=%h line=%0d)", req, video, exp, dots, scan_line);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; load_n = 1'b1; inhibit = 1'b0; blank = 1'b0;
    step();
    rst = 1'b0;
  endtask

  // Stream one word; optional pause of 3 inhibited cycles after dot pause_at.
  task automatic stream(input logic [7:0] d, input logic ul, input logic [3:0] sl,
                        input int pause_at);
    logic hit;
    logic e;
    hit = ul && (sl == 4'd8);
    do_reset();
    check(1'b0, "R9 reset");
    underline = ul; scan_line = sl;
    dots = d; load_n = 1'b0; inhibit = (pause_at >= 0); // R1: load wins over inhibit
    step();
    load_n = 1'b0; load_n = 1'b1; inhibit = 1'b0;
    step();
    for (int k = 0; k <= 8; k++) begin
      step();
      e = hit ? 1'b1 : (bitof(d, k) | bitof(d, k - 1));
      check(e, hit ? "R6 underline" : "R3/R4 stretch");
      if (k == pause_at) begin
        inhibit = 1'b1;
        for (int j = 0; j < 3; j++) begin
          step();
          check(e, "R5 inhibit hold");
        end
        inhibit = 1'b0;
      end
    end
    underline = 1'b0; scan_line = '0;
  endtask

  task automatic blank_case(input logic [7:0] d);
    do_reset();
    dots = d; load_n = 1'b0;
    step();
    load_n = 1'b1;
    step();
    for (int k = 0; k <= 2; k++) begin
      step();
      check(bitof(d, k) | bitof(d, k - 1), "R4 stretch before blank");
    end
    blank = 1'b1; underline = 1'b1; scan_line = 4'd8;
    step();
    check(1'b0, "R8 blank over underline");
    blank = 1'b0; underline = 1'b0; scan_line = '0;
    step();
    check(1'b0, "R7 latch cleared");
    step();
    check(bitof(d, 5), "R7 stream after blank");
  endtask

  task automatic reset_mid(input logic [7:0] d);
    do_reset();
    dots = d; load_n = 1'b0;
    step();
    load_n = 1'b1;
    step(); step(); step();
    rst = 1'b1;
    step();
    rst = 1'b0;
    check(1'b0, "R9 reset mid stream");
    for (int k = 0; k < 10; k++) begin
      step();
      check(1'b0, "R9 register cleared");
    end
  endtask

  initial begin
    step();
    // R1 R2 R3 R4: every word, LSB first, stretched, zero fill
    for (int d = 0; d < 256; d++) stream(8'(d), 1'b0, 4'd0, -1);
    // R5: inhibit pause at a varying dot
    for (int d = 0; d < 256; d++) stream(8'(d), 1'b0, 4'd3, d % 9);
    // R6: underline only on line 8
    for (int s = 0; s < 16; s++) begin
      stream(8'h00, 1'b1, 4'(s), -1);
      stream(8'h5A, 1'b1, 4'(s), -1);
      stream(8'h81, 1'b1, 4'(s), s % 9);
    end
    stream(8'h00, 1'b0, 4'd8, -1);
    // R7 R8: blank
    blank_case(8'hFF);
    blank_case(8'hA5);
    blank_case(8'h20);
    // R9
    reset_mid(8'hFF);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule